// File: doc/BRIEF.md
# Sticky Stereo Peak Level Monitor

This block watches the two signed sample streams leaving a stereo analog-to-digital path, ahead of any limiting stage, and keeps for each channel a 3-bit code for the loudest sample seen since the status was last read. The code sorts the sample magnitude into 1 dB bins between −6 dBFS and full scale. Code 0 means the level stayed below −6 dBFS. Codes 1 through 6 mark −6 up to −1 dBFS. Code 7 marks clipping.

The held codes are packed into a status byte together with two acceptance flags supplied from outside the block. When software reads the byte, the fields are returned and then cleared, so each read reports the peak of the interval since the previous read. A sample that arrives in the same cycle as the read is not lost. It becomes the first entry of the new interval.

Top module: `peak_level_monitor`

## Requirements
- R1: After reset both level fields of the status byte read 0.
- R2: For a sample magnitude M (20-bit samples, full scale F = 524287), the level code is 7 if M >= F. Otherwise it is 6 for M >= 467272, 5 for M >= 416456, 4 for M >= 371167, 3 for M >= 330803, 2 for M >= 294829, 1 for M >= 262766, and 0 below 262766.
- R3: The magnitude of a negative two's-complement sample is its absolute value. The most negative sample, −524288, yields code 7.
- R4: A held code only rises. A later sample with a lower code leaves it unchanged until a read.
- R5: The left and right channels are tracked separately. A sample on one channel never changes the other channel's field.
- R6: While the read strobe is high, the status byte shows the held codes. In the following cycle both level fields are 0, unless R7 applies.
- R7: If a valid sample and the read strobe arrive in the same cycle, the held code after that cycle is that sample's code, not 0.
- R8: Status byte layout: bit 7 is the right acceptance flag, bit 6 is the left acceptance flag, bits 5:3 hold the right level code and bits 2:0 hold the left level code. The acceptance bits follow their inputs in the same cycle.
- R9: Sample words presented while the valid strobe is low have no effect on the level fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample pair strobe |
| smp_left | input | 20 | Left sample, two's complement |
| smp_right | input | 20 | Right sample, two's complement |
| accept_left | input | 1 | Left acceptance flag to report |
| accept_right | input | 1 | Right acceptance flag to report |
| rd_strobe | input | 1 | Status byte read, clears level fields |
| status_byte | output | 8 | Packed acceptance flags and level codes |

## Verification
Two functions can fall in the same cycle: clearing the fields on a read, and capturing a new peak. The random stimulus asserts the read strobe on about one cycle in eight while samples arrive on most cycles, so the two coincide often. Directed steps also force the overlap with a clipping sample and with a quiet one. The bench's reference model applies the rule that the incoming code replaces the cleared value, and it compares the next status byte against that.

// File: rtl/peak_level_monitor.sv
module peak_level_monitor #(
  parameter int SAMPLE_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic                accept_left,
  input  logic                accept_right,
  input  logic                rd_strobe,
  output logic [7:0]          status_byte
);

  localparam int CODE_W = 3;
  localparam longint FS20 = 524287;
  localparam longint FS = (64'sd1 <<< (SAMPLE_W - 1)) - 1;

  localparam longint T1_20 = 467272;
  localparam longint T2_20 = 416456;
  localparam longint T3_20 = 371167;
  localparam longint T4_20 = 330803;
  localparam longint T5_20 = 294829;
  localparam longint T6_20 = 262766;

  localparam logic [SAMPLE_W-1:0] FULL  = SAMPLE_W'(FS);
  localparam logic [SAMPLE_W-1:0] THR_1 = SAMPLE_W'((T1_20 * FS + FS20 - 1) / FS20);
  localparam logic [SAMPLE_W-1:0] THR_2 = SAMPLE_W'((T2_20 * FS + FS20 - 1) / FS20);
  localparam logic [SAMPLE_W-1:0] THR_3 = SAMPLE_W'((T3_20 * FS + FS20 - 1) / FS20);
  localparam logic [SAMPLE_W-1:0] THR_4 = SAMPLE_W'((T4_20 * FS + FS20 - 1) / FS20);
  localparam logic [SAMPLE_W-1:0] THR_5 = SAMPLE_W'((T5_20 * FS + FS20 - 1) / FS20);
  localparam logic [SAMPLE_W-1:0] THR_6 = SAMPLE_W'((T6_20 * FS + FS20 - 1) / FS20);

  function automatic logic [CODE_W-1:0] level_code(input logic [SAMPLE_W-1:0] s);
    logic [SAMPLE_W-1:0] mag;
    mag = s[SAMPLE_W-1] ? (~s + 1'b1) : s;
    if (mag >= FULL)       level_code = 3'd7;
    else if (mag >= THR_1) level_code = 3'd6;
    else if (mag >= THR_2) level_code = 3'd5;
    else if (mag >= THR_3) level_code = 3'd4;
    else if (mag >= THR_4) level_code = 3'd3;
    else if (mag >= THR_5) level_code = 3'd2;
    else if (mag >= THR_6) level_code = 3'd1;
    else                   level_code = 3'd0;
  endfunction

  logic [CODE_W-1:0] code_l, code_r;
  logic [CODE_W-1:0] held_l, held_r;

  assign code_l = level_code(smp_left);
  assign code_r = level_code(smp_right);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_l <= '0;
      held_r <= '0;
    end else if (rd_strobe) begin
      held_l <= smp_valid ? code_l : '0;
      held_r <= smp_valid ? code_r : '0;
    end else if (smp_valid) begin
      if (code_l > held_l) held_l <= code_l;
      if (code_r > held_r) held_r <= code_r;
    end
  end

  assign status_byte = {accept_right, accept_left, held_r, held_l};

endmodule

// File: rtl/peak_level_monitor_chk.sv
module peak_level_monitor_chk #(
  parameter int SAMPLE_W = 20
) (
  input logic                clk,
  input logic                rst_n,
  input logic                smp_valid,
  input logic [SAMPLE_W-1:0] smp_left,
  input logic [SAMPLE_W-1:0] smp_right,
  input logic                rd_strobe,
  input logic [7:0]          status_byte
);

  localparam logic [SAMPLE_W-1:0] POS_FULL = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic [SAMPLE_W-1:0] NEG_FULL = {1'b1, {(SAMPLE_W-1){1'b0}}};

  // R6
  clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && !smp_valid |=> status_byte[5:0] == 6'd0);

  // R4
  left_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> status_byte[2:0] >= $past(status_byte[2:0]));

  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid && !rd_strobe |=> $stable(status_byte[5:0]));

  // R3
  neg_full_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && smp_right == NEG_FULL |=> status_byte[5:3] == 3'd7);

  // R7
  read_keeps_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && smp_valid && smp_left == POS_FULL |=> status_byte[2:0] == 3'd7);

endmodule

bind peak_level_monitor peak_level_monitor_chk #(.SAMPLE_W(SAMPLE_W)) i_chk (
  .clk(clk),
  .rst_n(rst_n),
  .smp_valid(smp_valid),
  .smp_left(smp_left),
  .smp_right(smp_right),
  .rd_strobe(rd_strobe),
  .status_byte(status_byte)
);

// File: tb/test_peak_level_monitor.sv
module test_peak_level_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int W = 20;
  localparam int FS = 524287;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [W-1:0] smp_left = '0, smp_right = '0;
  logic accept_left = 1'b0, accept_right = 1'b0;
  logic rd_strobe = 1'b0;
  logic [7:0] status_byte;

  int total = 0;
  int bad = 0;
  int thr [1:6];
  logic [2:0] exp_l = 3'd0, exp_r = 3'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  peak_level_monitor #(.SAMPLE_W(W)) i_peak_level_monitor (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .smp_left(smp_left), .smp_right(smp_right),
    .accept_left(accept_left), .accept_right(accept_right),
    .rd_strobe(rd_strobe), .status_byte(status_byte)
  );

  function automatic logic [2:0] ref_code(input logic [W-1:0] s);
    int mag;
    mag = s[W-1] ? -$signed({{12{s[W-1]}}, s}) : int'(s);
    if (mag >= FS) return 3'd7;
    for (int k = 1; k <= 6; k++)
      if (mag >= thr[k]) return 3'(7 - k);
    return 3'd0;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [W-1:0] l, input logic [W-1:0] r,
                      input logic rd, input logic al, input logic ar, input string tag);
    logic [2:0] cl, cr;
    @(negedge clk);
    smp_valid = v; smp_left = l; smp_right = r; rd_strobe = rd;
    accept_left = al; accept_right = ar;
    #1;
    check(tag, status_byte, {ar, al, exp_r, exp_l});
    cl = ref_code(l); cr = ref_code(r);
    if (rd) begin
      exp_l = v ? cl : 3'd0;
      exp_r = v ? cr : 3'd0;
    end else if (v) begin
      if (cl > exp_l) exp_l = cl;
      if (cr > exp_r) exp_r = cr;
    end
  endtask

  function automatic logic [W-1:0] neg(input int m);
    return W'(-m);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 1; k <= 6; k++)
      thr[k] = int'($ceil(FS * (10.0 ** (-k / 20.0))));
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(0, '0, '0, 0, 0, 0, "R1 reset");
    step(0, '0, '0, 0, 1, 0, "R8 layout left acc");
    step(0, '0, '0, 0, 0, 1, "R8 layout right acc");
    // R2 exact bin edges and one below, left then read
    for (int k = 1; k <= 6; k++) begin
      step(1, W'(thr[k]), W'(thr[k] - 1), 0, 0, 0, "R2 edge");
      step(0, '0, '0, 1, 0, 0, "R2 edge read");
      step(0, '0, '0, 0, 0, 0, "R6 cleared");
    end
    step(1, W'(FS), W'(thr[6] - 1), 0, 0, 0, "R2 clip");
    step(0, '0, '0, 1, 0, 0, "R2 clip read");
    // R3 negative magnitude and most negative
    step(1, neg(thr[3]), {1'b1, {(W-1){1'b0}}}, 0, 0, 0, "R3 negative");
    step(0, '0, '0, 1, 1, 1, "R3 read");
    step(1, neg(FS), neg(thr[6] - 1), 0, 0, 0, "R3 neg full");
    step(0, '0, '0, 1, 0, 0, "R3 read2");
    // R4 sticky, R5 independent
    step(1, W'(thr[2]), '0, 0, 0, 0, "R4 set");
    step(1, W'(thr[6]), '0, 0, 0, 0, "R4 lower ignored");
    step(1, '0, W'(FS), 0, 0, 0, "R5 right only");
    step(0, '0, '0, 0, 0, 0, "R5 left kept");
    // R9 invalid samples ignored
    step(0, W'(FS), W'(FS), 0, 0, 0, "R9 invalid");
    step(0, '0, '0, 0, 0, 0, "R9 after invalid");
    // R7 read and peak together
    step(1, W'(FS), W'(thr[4]), 1, 0, 0, "R7 overlap");
    step(1, '0, '0, 1, 0, 0, "R7 kept peak");
    step(0, '0, '0, 0, 0, 0, "R7 quiet overlap");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [W-1:0] l, r;
      int sel;
      sel = $urandom_range(0, 3);
      if (sel == 0) l = W'($urandom);
      else begin
        l = W'(thr[$urandom_range(1, 6)] + $urandom_range(0, 2) - 1);
        if ($urandom_range(0, 1) == 1) l = W'(-int'(l));
      end
      sel = $urandom_range(0, 3);
      if (sel == 0) r = W'($urandom);
      else if (sel == 1) r = {1'b1, {(W-1){1'b0}}};
      else r = W'($urandom_range(0, FS));
      step($urandom_range(0, 3) != 0, l, r, $urandom_range(0, 7) == 0,
           1'($urandom), 1'($urandom), "R4 R6 R7 random");
    end
    step(0, '0, '0, 0, 0, 0, "R2 final");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule